// File: doc/BRIEF.md
# Multiple Register Transfer Sequencer

This block runs a load-multiple or store-multiple operation for a processor with sixteen general registers. The operation arrives as one request. The request carries a register selection mask, the index of the base register, the current base value and five control flags: pre/post indexing, up/down direction, user-bank, writeback and load/store. From these the block works out the first memory address and the written-back base value before any transfer starts. It then issues one word access per selected register.

Each transfer is a single request on a simple memory port. The transfer completes in any cycle where the request is high and the ready input is high. Store data is fetched through a combinational register-file read port. Load data returns through a register-file write port in the cycle it is accepted. The base register has its own write strobe, so a base update and a loaded register can be written in the same cycle. The user-bank flag is not acted on. It is only held stable on an output for the length of the operation.

The block does not decode instructions, does not model memory and does not switch register banks.

Top module: `mrt_seq`

## Requirements
- R1: With the up flag set, the first access goes to base+4 when pre-indexed and to base when post-indexed.
- R2: With the up flag clear and N registers selected, the first access goes to base-4N when pre-indexed and to base-4N+4 when post-indexed.
- R3: Selected registers are transferred in ascending index order, lowest first. Each later access is 4 above the previous one, whatever the direction flag says.
- R4: The written-back base value is base+4N when counting up and base-4N when counting down.
- R5: With an all-zero selection mask, exactly one transfer takes place, on register 15 (the program counter). A load writes the read word into register 15. A store writes register 15's value plus 8. The base is always written with base+0x40 (up) or base-0x40 (down), in the cycle of that transfer.
- R6: For a store with writeback and a non-empty mask, the base strobe fires in the cycle of the first transfer. Any later store of the base register therefore sends the updated value.
- R7: For a load with writeback and a non-empty mask, the base strobe fires in the cycle of the last transfer, and only when the base register is not in the mask. If it is in the mask, the loaded word is the only write to it.
- R8: A start pulse is accepted only while busy is low. Busy is high from the next cycle until the last transfer completes. Done is a one-cycle pulse in the cycle after the last transfer, with busy low. While ready is low, the request, the address and the register index hold.
- R9: Every address presented while busy has its two low bits at zero.
- R10: The user-bank flag captured at start is presented on its output and held unchanged for the whole operation.
- R11: With a non-empty mask and writeback clear, the base strobe never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| start | input | 1 | Request pulse, taken when not busy |
| reg_list | input | 16 | Register selection mask, bit 15 is the program counter |
| base_idx | input | 4 | Index of the base register |
| base_val | input | 32 | Current value of the base register |
| mode_pre | input | 1 | 1: pre-indexed, 0: post-indexed |
| mode_up | input | 1 | 1: addresses rise from the base, 0: fall below it |
| mode_usr | input | 1 | User-bank flag, passed through |
| mode_wb | input | 1 | Write the base back |
| mode_ld | input | 1 | 1: load, 0: store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a store access |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_rdy |
| mem_rdy | input | 1 | Access accepted this cycle |
| usr_bank_o | output | 1 | Captured user-bank flag |
| rf_rd_idx | output | 4 | Register-file read index (register being transferred) |
| rf_rd_data | input | 32 | Register-file read data, combinational |
| rf_wr_en | output | 1 | Register-file write strobe for loads |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| base_wr_en | output | 1 | Base register write strobe |
| base_wr_idx | output | 4 | Base register index for the write |
| base_wr_data | output | 32 | New base value |

## Verification
The assertions assume the following about the block's inputs:
- mem_rdata and rf_rd_data are valid in the same cycle they are used, with no latency.
- The base value arrives word aligned.
- An empty mask never names register 15 as its base.

The scoreboard bench keeps to these assumptions. Its register-file and memory models answer combinationally. It passes only aligned bases, and it drives base_val from its own copy of the base register. Ready is driven from a shift-register pattern so that stalls fall at varied points inside transfers. Each expected transfer and each base write is queued in advance, together with the ordinal of the transfer it must coincide with.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  // Flags captured at start and held for the whole operation.
  typedef struct packed {
    logic usr;     // user-bank flag, passed through
    logic wb;      // base writeback requested
    logic ld;      // 1: load, 0: store
    logic empty;   // selection mask was all zero
    logic inlist;  // base register is part of the mask
  } op_ctl_t;

endpackage

// File: rtl/mrt_rst_sync.sv
module mrt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/mrt_addr_calc.sv
module mrt_addr_calc #(
  parameter int unsigned NREG       = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned EMPTY_SPAN = 64
) (
  input  logic [NREG-1:0]           sel,
  input  logic [AW-1:0]             base,
  input  logic                      pre,
  input  logic                      up,
  output logic [$clog2(NREG+1)-1:0] count,
  output logic [AW-1:0]             first_addr,
  output logic [AW-1:0]             new_base
);

  localparam int unsigned CW = $clog2(NREG+1);
  localparam logic [AW-1:0] STEP  = AW'(WORD_BYTES);
  localparam logic [AW-1:0] ALIGN = ~(AW'(WORD_BYTES) - AW'(1));

  logic [AW-1:0] span;
  logic [AW-1:0] wb_span;
  logic [AW-1:0] raw_first;
  logic [AW-1:0] raw_nbase;

  // population count of the selection mask
  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CW'(sel[i]);
    end
  end

  always_comb begin
    span    = AW'(count) * STEP;
    wb_span = (count == '0) ? AW'(EMPTY_SPAN) : span;
    if (up) begin
      raw_first = base + (pre ? STEP : '0);
      raw_nbase = base + wb_span;
    end else begin
      raw_first = base - span + (pre ? '0 : STEP);
      raw_nbase = base - wb_span;
    end
    first_addr = raw_first & ALIGN;
    new_base   = raw_nbase & ALIGN;
  end

endmodule

// File: rtl/mrt_pick.sv
module mrt_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]         vec,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] idx
);

  localparam int unsigned IW = $clog2(N);

  // lowest set bit wins
  for (genvar g = 0; g < N; g++) begin : g_gnt
    if (g == 0) begin : g_lsb
      assign grant[g] = vec[g];
    end else begin : g_upper
      assign grant[g] = vec[g] & ~(|vec[g-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/mrt_seq.sv
module mrt_seq #(
  parameter int unsigned NREG         = 16,
  parameter int unsigned AW           = 32,
  parameter int unsigned DW           = 32,
  parameter int unsigned WORD_BYTES   = 4,
  parameter int unsigned EMPTY_SPAN   = 64,
  parameter int unsigned PC_STORE_OFS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NREG-1:0]         reg_list,
  input  logic [$clog2(NREG)-1:0] base_idx,
  input  logic [AW-1:0]           base_val,
  input  logic                    mode_pre,
  input  logic                    mode_up,
  input  logic                    mode_usr,
  input  logic                    mode_wb,
  input  logic                    mode_ld,
  output logic                    busy,
  output logic                    done,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_rdy,
  output logic                    usr_bank_o,
  output logic [$clog2(NREG)-1:0] rf_rd_idx,
  input  logic [DW-1:0]           rf_rd_data,
  output logic                    rf_wr_en,
  output logic [$clog2(NREG)-1:0] rf_wr_idx,
  output logic [DW-1:0]           rf_wr_data,
  output logic                    base_wr_en,
  output logic [$clog2(NREG)-1:0] base_wr_idx,
  output logic [AW-1:0]           base_wr_data
);

  import mrt_pkg::*;

  localparam int unsigned IW     = $clog2(NREG);
  localparam int unsigned CW     = $clog2(NREG+1);
  localparam int unsigned LSB    = $clog2(WORD_BYTES);
  localparam int unsigned PC_IDX = NREG - 1;
  localparam logic [AW-1:0]   STEP   = AW'(WORD_BYTES);
  localparam logic [NREG-1:0] PC_BIT = NREG'(1) << PC_IDX;

  logic rst_ns;

  mrt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  // start-of-operation arithmetic
  logic [CW-1:0] calc_cnt;
  logic [AW-1:0] calc_first;
  logic [AW-1:0] calc_nbase;

  mrt_addr_calc #(
    .NREG       (NREG),
    .AW         (AW),
    .WORD_BYTES (WORD_BYTES),
    .EMPTY_SPAN (EMPTY_SPAN)
  ) u_calc (
    .sel        (reg_list),
    .base       (base_val),
    .pre        (mode_pre),
    .up         (mode_up),
    .count      (calc_cnt),
    .first_addr (calc_first),
    .new_base   (calc_nbase)
  );

  // state
  logic            busy_q,  busy_d;
  logic            done_q,  done_d;
  logic [NREG-1:0] pend_q,  pend_d;
  logic [AW-1:0]   addr_q,  addr_d;
  logic [AW-1:0]   nbase_q, nbase_d;
  logic            first_q, first_d;
  logic [IW-1:0]   bidx_q,  bidx_d;
  op_ctl_t         ctl_q,   ctl_d;

  // pending-register selection
  logic [NREG-1:0] cur_grant;
  logic [IW-1:0]   cur_idx;

  mrt_pick #(.N(NREG)) u_pick (
    .vec   (pend_q),
    .grant (cur_grant),
    .idx   (cur_idx)
  );

  logic            accept;
  logic            fire;
  logic            last;
  logic [NREG-1:0] rest;
  logic            dp_en;

  assign accept = start & ~busy_q;
  assign fire   = busy_q & mem_rdy;
  assign rest   = pend_q & ~cur_grant;
  assign last   = fire & ~(|rest);
  assign dp_en  = accept | fire;

  // next state
  always_comb begin
    busy_d  = busy_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    nbase_d = nbase_q;
    first_d = first_q;
    bidx_d  = bidx_q;
    ctl_d   = ctl_q;
    done_d  = last;
    if (accept) begin
      busy_d       = 1'b1;
      pend_d       = (calc_cnt == '0) ? PC_BIT : reg_list;
      addr_d       = calc_first;
      nbase_d      = calc_nbase;
      first_d      = 1'b1;
      bidx_d       = base_idx;
      ctl_d.usr    = mode_usr;
      ctl_d.wb     = mode_wb;
      ctl_d.ld     = mode_ld;
      ctl_d.empty  = (calc_cnt == '0);
      ctl_d.inlist = reg_list[base_idx];
    end else if (fire) begin
      pend_d  = rest;
      addr_d  = addr_q + STEP;
      first_d = 1'b0;
      if (last) busy_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      nbase_q <= '0;
      first_q <= 1'b0;
      bidx_q  <= '0;
      ctl_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (dp_en) begin
        pend_q  <= pend_d;
        addr_q  <= addr_d;
        nbase_q <= nbase_d;
        first_q <= first_d;
        bidx_q  <= bidx_d;
        ctl_q   <= ctl_d;
      end
    end
  end

  // outputs
  assign busy       = busy_q;
  assign done       = done_q;
  assign usr_bank_o = ctl_q.usr;

  assign mem_req   = busy_q;
  assign mem_we    = busy_q & ~ctl_q.ld;
  assign mem_addr  = addr_q;
  assign rf_rd_idx = cur_idx;
  assign mem_wdata = ctl_q.empty ? (rf_rd_data + DW'(PC_STORE_OFS)) : rf_rd_data;

  assign rf_wr_en   = fire & ctl_q.ld;
  assign rf_wr_idx  = cur_idx;
  assign rf_wr_data = mem_rdata;

  assign base_wr_en   = fire & ( ctl_q.empty
                               | (ctl_q.wb & ~ctl_q.ld & first_q)
                               | (ctl_q.wb &  ctl_q.ld & ~ctl_q.inlist & last));
  assign base_wr_idx  = bidx_q;
  assign base_wr_data = nbase_q;

  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_q |-> (mem_addr[LSB-1:0] == '0));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    fire |=> (!busy_q || mem_addr == $past(mem_addr) + STEP));

  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    fire |=> (!busy_q || rf_rd_idx > $past(rf_rd_idx)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_q && !mem_rdy) |=> (busy_q && $stable(mem_addr) && $stable(rf_rd_idx)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done_q |-> !busy_q);

  // R7
  ld_base_late_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (base_wr_en && ctl_q.ld && !ctl_q.empty) |=> !busy_q);

  // R10
  usr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_q && $past(busy_q)) |-> $stable(usr_bank_o));

endmodule

// File: tb/sim_mrt_seq.sv
`timescale 1ns/1ps
module sim_mrt_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] reg_list;
  logic [3:0]  base_idx;
  logic [31:0] base_val;
  logic        mode_pre, mode_up, mode_usr, mode_wb, mode_ld;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rdy;
  logic        usr_bank_o;
  logic [3:0]  rf_rd_idx, rf_wr_idx, base_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, base_wr_data;
  logic        rf_wr_en, base_wr_en;

  always #2.5 clk = ~clk;

  mrt_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
    .base_idx(base_idx), .base_val(base_val), .mode_pre(mode_pre),
    .mode_up(mode_up), .mode_usr(mode_usr), .mode_wb(mode_wb), .mode_ld(mode_ld),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .usr_bank_o(usr_bank_o), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .base_wr_en(base_wr_en), .base_wr_idx(base_wr_idx),
    .base_wr_data(base_wr_data)
  );

  localparam logic [31:0] MEM_KEY = 32'h5A5A_0000;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // register file and memory models
  logic [31:0] rf [16];
  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata  = mem_addr ^ MEM_KEY;

  always @(posedge clk) begin
    if (rf_wr_en)   rf[rf_wr_idx]   <= rf_wr_data;
    if (base_wr_en) rf[base_wr_idx] <= base_wr_data;
  end

  // ready pattern
  logic [7:0] lfsr = 8'hB5;
  bit stall_en = 1'b0;
  always @(posedge clk) begin
    #1;
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy <= stall_en ? lfsr[0] : 1'b1;
  end

  // scoreboard items
  typedef struct {
    logic [3:0]  idx;
    logic [31:0] addr;
    logic        we;
    logic [31:0] data;
    string       tag;
  } xfer_t;

  typedef struct {
    int          at;
    logic [3:0]  idx;
    logic [31:0] val;
    string       tag;
  } bwr_t;

  xfer_t xq[$];
  bwr_t  bq[$];
  int    fires = 0;
  logic  exp_usr = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && busy) begin
      chk(usr_bank_o == exp_usr, "R10 user flag held", {31'd0, usr_bank_o}, {31'd0, exp_usr});
      if (mem_rdy) begin
        fires++;
        if (xq.size() == 0) begin
          chk(1'b0, "R3 unexpected transfer", mem_addr, 32'h0);
        end else begin
          xfer_t e;
          e = xq.pop_front();
          chk(mem_addr == e.addr, {e.tag, " address"}, mem_addr, e.addr);
          chk(mem_we == e.we, {e.tag, " direction"}, {31'd0, mem_we}, {31'd0, e.we});
          if (e.we) begin
            chk(rf_rd_idx == e.idx, {e.tag, " store index"}, {28'd0, rf_rd_idx}, {28'd0, e.idx});
            chk(mem_wdata == e.data, {e.tag, " store data"}, mem_wdata, e.data);
          end else begin
            chk(rf_wr_en && rf_wr_idx == e.idx, {e.tag, " load index"}, {28'd0, rf_wr_idx}, {28'd0, e.idx});
            chk(rf_wr_data == e.data, {e.tag, " load data"}, rf_wr_data, e.data);
          end
        end
      end
    end
    if (rst_n && base_wr_en) begin
      if (bq.size() == 0) begin
        chk(1'b0, "R11 unexpected base write", base_wr_data, 32'h0);
      end else begin
        bwr_t b;
        b = bq.pop_front();
        chk(base_wr_data == b.val, {b.tag, " base value"}, base_wr_data, b.val);
        chk(base_wr_idx == b.idx, {b.tag, " base index"}, {28'd0, base_wr_idx}, {28'd0, b.idx});
        chk(fires == b.at, {b.tag, " base write timing"}, fires, b.at);
      end
    end
  end

  // driver
  task automatic run_op(input logic [15:0] sel, input logic [3:0] bi, input logic [31:0] base,
                        input bit pre, input bit up, input bit usr, input bit wb, input bit ld,
                        input bit stall, input string tag);
    int n;
    int k;
    bit first;
    bit seen;
    logic [31:0] st, nb, span, a;
    logic [31:0] s [16];
    xfer_t e;
    bwr_t  b;
    @(posedge clk); #1;
    rf[bi] = base;
    for (int i = 0; i < 16; i++) s[i] = rf[i];
    n = $countones(sel);
    if (up) st = base + (pre ? 32'd4 : 32'd0);
    else    st = base - 32'(4 * n) + (pre ? 32'd0 : 32'd4);
    span = (n == 0) ? 32'h40 : 32'(4 * n);
    nb   = up ? base + span : base - span;
    if (n == 0) begin
      e.idx = 4'd15; e.addr = st; e.we = !ld;
      e.data = ld ? (st ^ MEM_KEY) : (s[15] + 32'd8);
      e.tag = {"R5 ", tag};
      xq.push_back(e);
      b.at = 1; b.idx = bi; b.val = nb; b.tag = {"R5 ", tag};
      bq.push_back(b);
    end else begin
      a = st; first = 1'b1; k = 0;
      for (int i = 0; i < 16; i++) begin
        if (sel[i]) begin
          e.idx = 4'(i); e.addr = a; e.we = !ld;
          if (ld) e.data = a ^ MEM_KEY;
          else    e.data = (4'(i) == bi && wb && !first) ? nb : s[i];
          e.tag = {"R3 ", tag};
          xq.push_back(e);
          a = a + 32'd4; first = 1'b0; k++;
        end
      end
      if (wb && !ld) begin
        b.at = 1; b.idx = bi; b.val = nb; b.tag = {"R6 R4 ", tag};
        bq.push_back(b);
      end
      if (wb && ld && !sel[bi]) begin
        b.at = n; b.idx = bi; b.val = nb; b.tag = {"R7 R4 ", tag};
        bq.push_back(b);
      end
    end
    fires = 0;
    exp_usr = usr;
    stall_en = stall;
    reg_list = sel; base_idx = bi; base_val = base;
    mode_pre = pre; mode_up = up; mode_usr = usr; mode_wb = wb; mode_ld = ld;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, {"R8 busy after start ", tag}, {31'd0, busy}, 32'd1);
    seen = 1'b0;
    for (int c = 0; c < 400 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, {"R8 done seen ", tag}, {31'd0, seen}, 32'd1);
    chk(busy == 1'b0, {"R8 idle at done ", tag}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, {"R8 done single pulse ", tag}, {31'd0, done}, 32'd0);
    chk(xq.size() == 0, {"R3 all transfers made ", tag}, xq.size(), 32'd0);
    chk(bq.size() == 0, {"R4 base writes made ", tag}, bq.size(), 32'd0);
    xq.delete();
    bq.delete();
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; reg_list = '0; base_idx = '0; base_val = '0;
    mode_pre = 1'b0; mode_up = 1'b0; mode_usr = 1'b0; mode_wb = 1'b0; mode_ld = 1'b0;
    mem_rdy = 1'b1;
    for (int i = 0; i < 16; i++) rf[i] = 32'hC000_0000 | (32'(i) << 8) | 32'(i);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R8 reset busy", {31'd0, busy}, 32'd0);
    chk(done == 1'b0, "R8 reset done", {31'd0, done}, 32'd0);
    chk(mem_req == 1'b0, "R8 reset request", {31'd0, mem_req}, 32'd0);
    chk(rf_wr_en == 1'b0, "R8 reset rf write", {31'd0, rf_wr_en}, 32'd0);
    chk(base_wr_en == 1'b0, "R11 reset base write", {31'd0, base_wr_en}, 32'd0);

    // R1 up, pre, store, no writeback (R11)
    run_op(16'h00F0, 4'd2, 32'h0000_1000, 1, 1, 0, 0, 0, 0, "R1 up pre store");
    // R1 up, post, store with writeback, base in mask after first (R6)
    run_op(16'h001C, 4'd3, 32'h0000_2000, 0, 1, 0, 1, 0, 0, "R1 R6 up post store wb");
    // R2 down, pre, load with writeback, base outside mask (R7), stalls
    run_op(16'h8421, 4'd6, 32'h0000_3000, 1, 0, 1, 1, 1, 1, "R2 R7 down pre load wb");
    // R2 down, post, store with writeback, base is the first register
    run_op(16'h0101, 4'd0, 32'h0000_4000, 0, 0, 0, 1, 0, 1, "R2 R6 down post store base first");
    // R5 empty mask load, up
    run_op(16'h0000, 4'd5, 32'h0000_5000, 1, 1, 0, 0, 1, 0, "R5 empty load up");
    // R5 empty mask store, down
    run_op(16'h0000, 4'd4, 32'h0000_6000, 0, 0, 1, 1, 0, 1, "R5 empty store down");
    // R7 load with writeback, base inside mask
    run_op(16'h0A80, 4'd9, 32'h0000_7000, 0, 1, 0, 1, 1, 1, "R7 load base in mask");
    // R11 load without writeback
    run_op(16'h0006, 4'd8, 32'h0000_8000, 1, 0, 0, 0, 1, 0, "R11 load no wb");
    // R3 full mask, down post load with stalls
    run_op(16'hFFFF, 4'd13, 32'h0001_0000, 0, 0, 1, 0, 1, 1, "R3 full mask load");
    // R6 single register store equal to base
    run_op(16'h0400, 4'd10, 32'h0000_9000, 1, 1, 1, 1, 0, 1, "R6 single base store");
    // R9 R3 full mask store up pre writeback, stalls
    run_op(16'hFFFF, 4'd7, 32'h0002_0000, 1, 1, 0, 1, 0, 1, "R9 full mask store wb");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule